// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps the results of instructions that have finished executing but have not yet updated architectural state. When an instruction issues, it takes the next free slot at the tail of a circular buffer. The slot number goes back to the issuing logic as the rename tag that consumers wait on. Results arrive on a common-data-bus port and are filed by tag. A store's address arrives on a separate port.

Operand logic can probe any tag. It learns whether the value exists and, if so, what it is. Architectural update happens strictly from the head, one instruction per cycle at most, and only after the head's result is present. A register operation becomes a register-file write, a store becomes a memory write request, and a branch simply retires.

When a branch turns out to be mispredicted, the buffer drops every slot allocated after that branch. It keeps the branch and everything older, and it broadcasts the branch's tag once as a squash-and-redirect pulse.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `mem_we`, `squash_valid` and `lk_ready` are all 0.
- R2: Accepted allocations receive consecutive tags modulo DEPTH, starting from the tail. `alloc_ready` is 0 while DEPTH entries are held or while `mp_valid` is high. An allocation attempted while `alloc_ready` is 0 changes nothing.
- R3: A `cdb_valid` write to a live tag stores `cdb_data`. A lookup of tag T presented in one cycle yields `lk_ready` and `lk_data` after the next clock edge. `lk_data` equals the stored value when the entry is done and 0 otherwise.
- R4: Only the oldest entry commits, at most one per cycle, and only once it is done. A younger done entry waits until every older entry has committed.
- R5: A register operation (`alloc_kind` 0) becomes done when its data arrives. Its commit raises `rf_we` for one cycle with `rf_idx` equal to the register given at allocation and `rf_data` equal to its result.
- R6: A store (`alloc_kind` 1) becomes done only after both its data (`cdb_*`) and its address (`st_addr_*`) have arrived, in either order. Its commit raises `mem_we` for one cycle with that address and data.
- R7: A branch (`alloc_kind` 2) becomes done on a data write or on a misprediction report. Its commit raises neither `rf_we` nor `mem_we`.
- R8: When `mp_valid` names a live branch tag, all younger entries are discarded and older entries still commit normally. The next allocated tag is that tag plus one, and after the next edge `squash_valid` pulses with `squash_tag` equal to the branch tag.
- R9: Slots freed by commit or by squash are reused by later allocations. Data, address and lookup references to tags that are not live have no effect: such lookups report not ready with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate an entry |
| alloc_kind | input | 2 | 0 register op, 1 store, 2 branch |
| alloc_reg | input | AREG_W | Destination register for register ops |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_tag | output | IDXW | Tag given to the allocated entry |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | IDXW | Tag of the broadcast result |
| cdb_data | input | DATA_W | Result value (store data for stores) |
| st_addr_valid | input | 1 | Store address valid |
| st_addr_tag | input | IDXW | Tag of the store receiving the address |
| st_addr | input | ADDR_W | Store address |
| mp_valid | input | 1 | Branch misprediction report |
| mp_tag | input | IDXW | Tag of the mispredicted branch |
| lk_tag | input | IDXW | Operand lookup tag |
| lk_ready | output | 1 | Looked-up entry is done (registered) |
| lk_data | output | DATA_W | Looked-up value, 0 if not done (registered) |
| rf_we | output | 1 | Register-file write from commit |
| rf_idx | output | AREG_W | Register written |
| rf_data | output | DATA_W | Value written |
| mem_we | output | 1 | Memory store request from commit |
| mem_addr | output | ADDR_W | Store address |
| mem_data | output | DATA_W | Store data |
| squash_valid | output | 1 | Flush younger entries and redirect fetch |
| squash_tag | output | IDXW | Tag of the branch that caused the squash |

## Verification
A fill-only phase drives allocations with no results, which shows where the buffer refuses at full and that refused requests leave the tail alone. A drain phase then returns results in scrambled order, which separates true head-only in-order retirement from simply retiring whatever is done. A long random mix interleaves stores whose address and data arrive in either order, mispredictions against live branches, and broadcasts to dead or stale tags. This mix shows whether store completion waits for both halves, whether a squash keeps the older entries while dropping the younger ones, and whether stale tags can leak into freshly reused slots.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2,
    K_RSVD   = 2'd3
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_go,
  input  logic            commit_go,
  input  logic            mp_go,
  input  logic [IDXW-1:0] mp_tag,
  output logic [IDXW-1:0] head_idx,
  output logic [IDXW-1:0] tail_idx,
  output logic [IDXW:0]   count,
  output logic            full
);
  logic [IDXW:0]   head_q, tail_q;
  logic [IDXW-1:0] keep_dist;
  logic [IDXW:0]   one_w;

  assign one_w     = {{IDXW{1'b0}}, 1'b1};
  assign keep_dist = mp_tag - head_q[IDXW-1:0];
  assign head_idx  = head_q[IDXW-1:0];
  assign tail_idx  = tail_q[IDXW-1:0];
  assign count     = tail_q - head_q;
  assign full      = (count == (IDXW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (commit_go)
        head_q <= head_q + one_w;
      if (mp_go)
        tail_q <= head_q + {1'b0, keep_dist} + one_w;
      else if (alloc_go)
        tail_q <= tail_q + one_w;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= (IDXW+1)'(DEPTH)); // R2
  AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (rst)
    alloc_go |-> !full); // R2
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (head_q != $past(head_q)) |-> (head_q == $past(head_q) + one_w)); // R4
endmodule

// File: rtl/rob_slots.sv
`timescale 1ns/1ps
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  parameter int ADDR_W = 32,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_go,
  input  logic [IDXW-1:0]   alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [AREG_W-1:0] alloc_reg,
  input  logic              cdb_go,
  input  logic [IDXW-1:0]   cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              sa_go,
  input  logic [IDXW-1:0]   sa_tag,
  input  logic [ADDR_W-1:0] sa_addr,
  input  logic              mark_go,
  input  logic [IDXW-1:0]   mark_tag,
  input  logic [IDXW-1:0]   head_idx,
  input  logic [IDXW-1:0]   lk_tag,
  output rob_kind_e         head_kind,
  output logic [AREG_W-1:0] head_reg,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              head_done,
  output logic              lk_done,
  output logic [DATA_W-1:0] lk_data
);
  rob_kind_e         kind_mem [DEPTH];
  logic [AREG_W-1:0] reg_mem  [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [DEPTH-1:0]  dval_q, aok_q, done_v;

  // Storage arrays: single write port each, no reset, so they map to distributed RAM.
  always_ff @(posedge clk) begin
    if (alloc_go) begin
      kind_mem[alloc_idx] <= alloc_kind;
      reg_mem[alloc_idx]  <= alloc_reg;
    end
  end
  always_ff @(posedge clk) begin
    if (cdb_go) data_mem[cdb_tag] <= cdb_data;
  end
  always_ff @(posedge clk) begin
    if (sa_go) addr_mem[sa_tag] <= sa_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dval_q <= '0;
      aok_q  <= '0;
    end else begin
      if (alloc_go) begin
        dval_q[alloc_idx] <= 1'b0;
        aok_q[alloc_idx]  <= 1'b0;
      end
      if (cdb_go)  dval_q[cdb_tag]  <= 1'b1;
      if (mark_go) dval_q[mark_tag] <= 1'b1;
      if (sa_go)   aok_q[sa_tag]    <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_done
    assign done_v[i] = dval_q[i] && ((kind_mem[i] != K_STORE) || aok_q[i]);
  end

  assign head_kind = kind_mem[head_idx];
  assign head_reg  = reg_mem[head_idx];
  assign head_addr = addr_mem[head_idx];
  assign head_data = data_mem[head_idx];
  assign head_done = done_v[head_idx];
  assign lk_done   = done_v[lk_tag];
  assign lk_data   = data_mem[lk_tag];
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  parameter int ADDR_W = 32,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [AREG_W-1:0] alloc_reg,
  output logic              alloc_ready,
  output logic [IDXW-1:0]   alloc_tag,
  input  logic              cdb_valid,
  input  logic [IDXW-1:0]   cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              st_addr_valid,
  input  logic [IDXW-1:0]   st_addr_tag,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              mp_valid,
  input  logic [IDXW-1:0]   mp_tag,
  input  logic [IDXW-1:0]   lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_data,
  output logic              rf_we,
  output logic [AREG_W-1:0] rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              squash_valid,
  output logic [IDXW-1:0]   squash_tag
);
  logic [IDXW-1:0]   head_idx, tail_idx;
  logic [IDXW:0]     count;
  logic              full, alloc_go, commit_go, mp_go, cdb_go, sa_go;
  rob_kind_e         head_kind;
  logic [AREG_W-1:0] head_reg;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data, lk_raw;
  logic              head_done, lk_done;

  function automatic logic live(input logic [IDXW-1:0] t, input logic [IDXW-1:0] h,
                                input logic [IDXW:0] n);
    logic [IDXW-1:0] off;
    off = t - h;
    return ({1'b0, off} < n);
  endfunction

  assign alloc_ready = !full && !mp_valid;
  assign alloc_tag   = tail_idx;
  assign alloc_go    = alloc_valid && alloc_ready;
  assign mp_go       = mp_valid && live(mp_tag, head_idx, count);
  assign cdb_go      = cdb_valid && live(cdb_tag, head_idx, count);
  assign sa_go       = st_addr_valid && live(st_addr_tag, head_idx, count);
  assign commit_go   = (count != '0) && head_done;

  rob_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst(rst), .alloc_go(alloc_go), .commit_go(commit_go),
    .mp_go(mp_go), .mp_tag(mp_tag), .head_idx(head_idx), .tail_idx(tail_idx),
    .count(count), .full(full)
  );

  rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W), .ADDR_W(ADDR_W)) slots_i (
    .clk(clk), .rst(rst), .alloc_go(alloc_go), .alloc_idx(tail_idx),
    .alloc_kind(rob_kind_e'(alloc_kind)), .alloc_reg(alloc_reg),
    .cdb_go(cdb_go), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .sa_go(sa_go), .sa_tag(st_addr_tag), .sa_addr(st_addr),
    .mark_go(mp_go), .mark_tag(mp_tag), .head_idx(head_idx), .lk_tag(lk_tag),
    .head_kind(head_kind), .head_reg(head_reg), .head_addr(head_addr),
    .head_data(head_data), .head_done(head_done), .lk_done(lk_done), .lk_data(lk_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we        <= 1'b0;
      mem_we       <= 1'b0;
      squash_valid <= 1'b0;
      lk_ready     <= 1'b0;
      rf_idx       <= '0;
      rf_data      <= '0;
      mem_addr     <= '0;
      mem_data     <= '0;
      squash_tag   <= '0;
      lk_data      <= '0;
    end else begin
      rf_we        <= commit_go && (head_kind == K_REG);
      mem_we       <= commit_go && (head_kind == K_STORE);
      if (commit_go) begin
        rf_idx   <= head_reg;
        rf_data  <= head_data;
        mem_addr <= head_addr;
        mem_data <= head_data;
      end
      squash_valid <= mp_go;
      if (mp_go) squash_tag <= mp_tag;
      lk_ready     <= lk_done && live(lk_tag, head_idx, count);
      lk_data      <= (lk_done && live(lk_tag, head_idx, count)) ? lk_raw : '0;
    end
  end

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, mem_we})); // R4
  AST_COMMIT_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (rf_we || mem_we) |-> ($past(count) != '0)); // R4
  AST_SQUASH_ECHO: assert property (@(posedge clk) disable iff (rst)
    mp_go |=> (squash_valid && squash_tag == $past(mp_tag))); // R8
  AST_NO_ALLOC_ON_MP: assert property (@(posedge clk) disable iff (rst)
    mp_valid |-> !alloc_ready); // R2
endmodule

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb_top;
  localparam int D  = 8;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int AW = 32;
  localparam int IW = 3;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic alloc_valid = 0; logic [1:0] alloc_kind = 0; logic [RW-1:0] alloc_reg = 0;
  logic alloc_ready; logic [IW-1:0] alloc_tag;
  logic cdb_valid = 0; logic [IW-1:0] cdb_tag = 0; logic [DW-1:0] cdb_data = 0;
  logic st_addr_valid = 0; logic [IW-1:0] st_addr_tag = 0; logic [AW-1:0] st_addr = 0;
  logic mp_valid = 0; logic [IW-1:0] mp_tag = 0; logic [IW-1:0] lk_tag = 0;
  logic lk_ready; logic [DW-1:0] lk_data;
  logic rf_we; logic [RW-1:0] rf_idx; logic [DW-1:0] rf_data;
  logic mem_we; logic [AW-1:0] mem_addr; logic [DW-1:0] mem_data;
  logic squash_valid; logic [IW-1:0] squash_tag;

  rob_core #(.DEPTH(D), .DATA_W(DW), .AREG_W(RW), .ADDR_W(AW)) dut_i (.*);

  int errors = 0, checks = 0;
  int m_kind[D]; int m_reg[D]; int unsigned m_addr[D]; int unsigned m_data[D];
  bit m_dv[D]; bit m_ao[D];
  int m_head = 0, m_count = 0;
  bit e_rf, e_mem, e_sq, e_lk; int e_idx, e_sqt; int unsigned e_data, e_addr, e_lkd;
  bit e_brc;
  int p_alloc, p_cdb, p_sa, p_mp, p_stale, force_kind;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit inwin(int t);
    return (((t - m_head) % D + D) % D) < m_count;
  endfunction
  function automatic bit done(int t);
    return m_dv[t] && (m_kind[t] != 1 || m_ao[t]);
  endfunction
  // Pick a live entry of a wanted kind (-1 any) still lacking data (w=0) or address (w=1).
  function automatic int pick(int want, int w);
    int s = int'($urandom % D);
    for (int k = 0; k < D; k++) begin
      int o = (s + k) % D;
      int t = (m_head + o) % D;
      if (o < m_count && (want < 0 || m_kind[t] == want) &&
          ((w == 0 && !m_dv[t]) || (w == 1 && !m_ao[t]))) return t;
    end
    return -1;
  endfunction

  task automatic step();
    int oh, oc, t, tail; bit hd, acc;
    // registered outputs from the last edge
    chk(rf_we == e_rf, e_brc ? "R7" : "R4", "rf_we", rf_we, e_rf);
    chk(mem_we == e_mem, e_brc ? "R7" : "R6", "mem_we", mem_we, e_mem);
    if (e_rf) begin
      chk(rf_idx == e_idx[RW-1:0], "R5", "rf_idx", rf_idx, e_idx);
      chk(rf_data == e_data, "R5", "rf_data", rf_data, e_data);
    end
    if (e_mem) begin
      chk(mem_addr == e_addr, "R6", "mem_addr", mem_addr, e_addr);
      chk(mem_data == e_data, "R6", "mem_data", mem_data, e_data);
    end
    chk(lk_ready == e_lk, "R3 R9", "lk_ready", lk_ready, e_lk);
    chk(lk_data == e_lkd, "R3 R9", "lk_data", lk_data, e_lkd);
    chk(squash_valid == e_sq, "R8", "squash_valid", squash_valid, e_sq);
    if (e_sq) chk(squash_tag == e_sqt[IW-1:0], "R8", "squash_tag", squash_tag, e_sqt);
    // stimulus
    alloc_valid = ($urandom % 100) < p_alloc;
    alloc_kind  = (force_kind >= 0) ? force_kind[1:0] : 2'($urandom % 3);
    alloc_reg   = RW'($urandom);
    mp_valid = 0;
    if (($urandom % 100) < p_mp) begin
      t = pick(2, 0);
      if (t >= 0) begin mp_valid = 1; mp_tag = IW'(t); end
    end
    cdb_valid = ($urandom % 100) < p_cdb;
    t = pick(-1, 0);
    cdb_tag  = (t < 0 || ($urandom % 100) < p_stale) ? IW'($urandom) : IW'(t);
    cdb_data = $urandom;
    if (mp_valid && cdb_tag == mp_tag) cdb_valid = 0;
    st_addr_valid = ($urandom % 100) < p_sa;
    t = pick(1, 1);
    st_addr_tag = (t < 0 || ($urandom % 100) < p_stale) ? IW'($urandom) : IW'(t);
    st_addr = $urandom;
    lk_tag = IW'($urandom);
    #1;
    oh = m_head; oc = m_count; tail = (oh + oc) % D;
    acc = (oc < D) && !mp_valid;
    chk(alloc_ready == acc, "R2", "alloc_ready", alloc_ready, acc);
    chk(alloc_tag == IW'(tail), "R2 R8", "alloc_tag", alloc_tag, tail);
    // model update
    hd = (oc > 0) && done(oh);
    e_brc = hd && m_kind[oh] == 2;
    e_rf  = hd && m_kind[oh] == 0;
    e_mem = hd && m_kind[oh] == 1;
    e_idx = m_reg[oh]; e_data = m_data[oh]; e_addr = m_addr[oh];
    e_lk  = inwin(int'(lk_tag)) && done(int'(lk_tag));
    e_lkd = e_lk ? m_data[lk_tag] : 0;
    e_sq  = mp_valid; e_sqt = int'(mp_tag);
    if (cdb_valid && inwin(int'(cdb_tag))) begin m_data[cdb_tag] = cdb_data; m_dv[cdb_tag] = 1; end
    if (st_addr_valid && inwin(int'(st_addr_tag))) begin
      m_addr[st_addr_tag] = st_addr; m_ao[st_addr_tag] = 1;
    end
    if (mp_valid) begin
      m_dv[mp_tag] = 1;
      m_count = ((int'(mp_tag) - oh + D) % D) + 1;
    end else if (alloc_valid && acc) begin
      m_kind[tail] = int'(alloc_kind); m_reg[tail] = int'(alloc_reg);
      m_dv[tail] = 0; m_ao[tail] = 0; m_count++;
    end
    if (hd) begin m_head = (oh + 1) % D; m_count--; end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0bb5_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
    chk(alloc_tag == 0, "R1", "alloc_tag", alloc_tag, 0);
    chk(rf_we == 0 && mem_we == 0, "R1", "commit strobes", {rf_we, mem_we}, 0);
    chk(squash_valid == 0, "R1", "squash_valid", squash_valid, 0);
    chk(lk_ready == 0, "R1", "lk_ready", lk_ready, 0);
    // Fill past full: R2 refusal, no results yet
    p_alloc = 100; p_cdb = 0; p_sa = 0; p_mp = 0; p_stale = 0; force_kind = 0;
    repeat (12) begin step(); @(negedge clk); end
    // Drain with results in scrambled order: R4 R5
    p_alloc = 0; p_cdb = 100;
    repeat (24) begin step(); @(negedge clk); end
    // Stores only, address and data in either order: R6
    force_kind = 1; p_alloc = 60; p_cdb = 50; p_sa = 50;
    repeat (200) begin step(); @(negedge clk); end
    // Full random mix with squashes and stale tags: R7 R8 R9
    force_kind = -1; p_alloc = 55; p_cdb = 45; p_sa = 40; p_mp = 6; p_stale = 20;
    repeat (4000) begin step(); @(negedge clk); end
    alloc_valid = 0; cdb_valid = 0; st_addr_valid = 0; mp_valid = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule